// File: doc/BRIEF.md
# No-turnaround synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It accepts a new read or write command on every rising clock edge. Reads and writes can alternate freely, with no idle cycle between them. The bus stays fully used because write data is not presented with its command. In pipelined mode it arrives two edges later, and in flow-through mode one edge later. Read data in pipelined mode passes through an output register. In flow-through mode it comes straight from the array.

A command is a load (`burst_adv` low) or an advance (`burst_adv` high). A load takes a new address and its read/write direction, and only does so when all three selects are active. An advance continues the last loaded operation at the next address of a four-word burst. The burst order is linear or interleaved. Writes have per-lane enables on 9-bit lanes. An asynchronous drive enable and an asynchronous doze input control the read drivers. Doze also blocks commands and array updates. The array is kept small so that it suits simulation.

Top module: `zws_sram`

## Requirements
- R1: A load is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0 at the rising edge. Any other combination is a deselect: nothing is written and no read data is driven.
- R2: In pipelined mode (`pipe_mode`=1), read data for a command taken at edge k is driven from just after edge k+1 until edge k+2.
- R3: In flow-through mode (`pipe_mode`=0), read data for a command taken at edge k is driven from just after edge k until edge k+1.
- R4: In pipelined mode, write data for a command taken at edge k is sampled from `wdata` at edge k+2.
- R5: In flow-through mode, write data for a command taken at edge k is sampled from `wdata` at edge k+1.
- R6: Reads and writes may follow each other on consecutive edges. A pipelined read whose output is registered on the same edge at which a write to the same address commits returns the newly written lanes merged with the old ones.
- R7: `lane_wr_n[b]`=0, sampled with the command, writes bits [9b+8:9b] of the word. The lanes whose enable is high keep their contents.
- R8: An advance repeats the last loaded operation. It keeps address bits above bit 1 fixed and ignores the selects and `wr_n`. The two low bits are start+n mod 4 when `burst_ilv`=0, or start XOR n when `burst_ilv`=1, for the n-th advance. An advance after a deselected load stays deselected.
- R9: `drv_en_n` high turns `rdata_drv` off and forces `rdata` to zero at once, with no clock edge needed.
- R10: While `doze` is high, commands are taken as deselects, the array is not written and `rdata_drv` is low at once.
- R11: While `rst_n` is low, `rdata_drv` is low and `rdata` is zero, and no command is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address for a load |
| sel0_n | input | 1 | Select, active low |
| sel1 | input | 1 | Select, active high |
| sel2_n | input | 1 | Select, active low |
| wr_n | input | 1 | 0 = write, 1 = read, for a load |
| lane_wr_n | input | NBYTES | Per-lane write enables, active low |
| burst_adv | input | 1 | 1 = advance the burst, 0 = load |
| drv_en_n | input | 1 | Asynchronous read drive enable, active low |
| doze | input | 1 | Asynchronous sleep request |
| pipe_mode | input | 1 | Static: 1 = pipelined, 0 = flow-through |
| burst_ilv | input | 1 | Static: 1 = interleaved, 0 = linear burst order |
| wdata | input | BYTE_W*NBYTES | Late write data |
| rdata | output | BYTE_W*NBYTES | Read data, zero when not driven |
| rdata_drv | output | 1 | High while read data is driven |

## Verification
A vector table runs pipelined write-write-read-read sequences in which reads and writes alternate on every edge. This separates a correct two-edge write-data delay from a one-edge delay, because each write's data sits in a different vector from its command. A partial-lane write is followed by a read whose output registers on the commit edge, which tells the merge path apart from a stale array read. Interleaved and linear bursts begin at a non-zero low address, so that XOR and addition give different address orders. Directed tests then switch each select off in turn and toggle the drive enable, doze and reset between edges, to separate the asynchronous controls from the clocked ones.

// File: rtl/zws_sram_pkg.sv
package zws_sram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } zws_op_e;

   // Low two address bits of the step-th word of a four-word burst.
   function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
      return ilv ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/zws_sram_cmd.sv
module zws_sram_cmd
   import zws_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              wr_n,
   input  logic [NBYTES-1:0] lane_wr_n,
   input  logic              burst_adv,
   input  logic              burst_ilv,
   input  logic              doze,
   output zws_op_e           s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [NBYTES-1:0] s1_be
);

   logic              sel;
   zws_op_e           load_op;
   zws_op_e           nxt_op;
   zws_op_e           burst_op_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] nxt_addr;
   logic [1:0]        cnt_q;
   logic [1:0]        cnt_nxt;

   always_comb begin
      sel     = ~sel0_n & sel1 & ~sel2_n;
      load_op = sel ? (wr_n ? OP_READ : OP_WRITE) : OP_IDLE;
      cnt_nxt = cnt_q + 2'd1;
      if (doze) begin
         nxt_op   = OP_IDLE;
         nxt_addr = addr;
      end else if (!burst_adv) begin
         nxt_op   = load_op;
         nxt_addr = addr;
      end else begin
         nxt_op   = burst_op_q;
         nxt_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_nxt, burst_ilv)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op      <= OP_IDLE;
         s1_addr    <= '0;
         s1_be      <= '0;
         burst_op_q <= OP_IDLE;
         base_q     <= '0;
         cnt_q      <= '0;
      end else begin
         s1_op   <= nxt_op;
         s1_addr <= nxt_addr;
         s1_be   <= ~lane_wr_n;
         if (!doze) begin
            if (!burst_adv) begin
               burst_op_q <= load_op;
               base_q     <= addr;
               cnt_q      <= '0;
            end else begin
               cnt_q <= cnt_nxt;
            end
         end
      end
   end

   // R1: a load with any select inactive issues nothing
   a_r1_deselect_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (!doze && !burst_adv && !sel) |=> (s1_op == OP_IDLE));

   // R10: doze turns the command into a deselect
   a_r10_doze_idle : assert property (@(posedge clk) disable iff (!rst_n)
      doze |=> (s1_op == OP_IDLE));

   // R8: an advance keeps the upper address and the operation
   a_r8_burst_upper : assert property (@(posedge clk) disable iff (!rst_n)
      (!doze && burst_adv && s1_op != OP_IDLE) |=>
         (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) && s1_op == $past(s1_op)));

endmodule

// File: rtl/zws_sram_wrpipe.sv
module zws_sram_wrpipe
   import zws_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  zws_op_e           s1_op,
   input  logic [ADDR_W-1:0] s1_addr,
   input  logic [NBYTES-1:0] s1_be,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [NBYTES-1:0] wr_be
);

   logic              s2_v;
   logic [ADDR_W-1:0] s2_addr;
   logic [NBYTES-1:0] s2_be;

   // Second stage of the pending-write queue, used only for the double-late write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_addr <= '0;
         s2_be   <= '0;
      end else begin
         s2_v    <= (s1_op == OP_WRITE);
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   // The commit happens at the edge where wdata is sampled.
   always_comb begin
      if (pipe_mode) begin
         wr_en   = s2_v;
         wr_addr = s2_addr;
         wr_be   = s2_be;
      end else begin
         wr_en   = (s1_op == OP_WRITE);
         wr_addr = s1_addr;
         wr_be   = s1_be;
      end
   end

   // R4: a pipelined write commits one stage later
   a_r4_double_late : assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && s1_op == OP_WRITE) |=> (wr_en || !pipe_mode));

endmodule

// File: rtl/zws_sram_array.sv
module zws_sram_array #(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [NBYTES-1:0]        wbe,
   input  logic [BYTE_W*NBYTES-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [BYTE_W*NBYTES-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] lane [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wbe[b]) lane[waddr] <= wdata[b*BYTE_W +: BYTE_W];
      end

      assign rdata[b*BYTE_W +: BYTE_W] = lane[raddr];
   end

endmodule

// File: rtl/zws_sram_rdpath.sv
module zws_sram_rdpath
   import zws_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pipe_mode,
   input  logic                     drv_en_n,
   input  logic                     doze,
   input  zws_op_e                  s1_op,
   input  logic [ADDR_W-1:0]        s1_addr,
   input  logic [BYTE_W*NBYTES-1:0] arr_rdata,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [NBYTES-1:0]        wr_be,
   input  logic [BYTE_W*NBYTES-1:0] wdata,
   output logic [BYTE_W*NBYTES-1:0] rdata,
   output logic                     rdata_drv
);

   localparam int WORD_W = BYTE_W * NBYTES;

   logic              hit;
   logic [WORD_W-1:0] merged;
   logic [WORD_W-1:0] q_data;
   logic              q_vld;
   logic [WORD_W-1:0] sel_data;
   logic              sel_vld;

   // A write committing on the same edge as the output register load.
   assign hit = wr_en & ~doze & (wr_addr == s1_addr);

   for (genvar b = 0; b < NBYTES; b++) begin : g_merge
      assign merged[b*BYTE_W +: BYTE_W] = (hit && wr_be[b]) ? wdata[b*BYTE_W +: BYTE_W]
                                                            : arr_rdata[b*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_data <= '0;
         q_vld  <= 1'b0;
      end else begin
         q_vld <= pipe_mode && (s1_op == OP_READ);
         if (pipe_mode && s1_op == OP_READ) q_data <= merged;
      end
   end

   always_comb begin
      sel_data  = pipe_mode ? q_data : arr_rdata;
      sel_vld   = pipe_mode ? q_vld : (s1_op == OP_READ);
      rdata_drv = sel_vld & ~drv_en_n & ~doze;
      rdata     = rdata_drv ? sel_data : '0;
   end

   // R2: a pipelined read is driven one edge after the command is registered
   a_r2_pipe_latency : assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && s1_op == OP_READ) |=> (rdata_drv || drv_en_n || doze || !pipe_mode));

   // R9 and R10: the asynchronous controls override the drivers
   a_r9_drive_off : assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en_n || doze) |-> (!rdata_drv && rdata == '0));

endmodule

// File: rtl/zws_sram.sv
module zws_sram
   import zws_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     sel0_n,
   input  logic                     sel1,
   input  logic                     sel2_n,
   input  logic                     wr_n,
   input  logic [NBYTES-1:0]        lane_wr_n,
   input  logic                     burst_adv,
   input  logic                     drv_en_n,
   input  logic                     doze,
   input  logic                     pipe_mode,
   input  logic                     burst_ilv,
   input  logic [BYTE_W*NBYTES-1:0] wdata,
   output logic [BYTE_W*NBYTES-1:0] rdata,
   output logic                     rdata_drv
);

   localparam int WORD_W = BYTE_W * NBYTES;

   if (ADDR_W < 2) begin : g_chk_addr
      $error("zws_sram: ADDR_W must cover the two burst bits");
   end
   if (BYTE_W < 1 || NBYTES < 1) begin : g_chk_word
      $error("zws_sram: BYTE_W and NBYTES must be positive");
   end
   if (ADDR_W > 12) begin : g_chk_depth
      $error("zws_sram: array kept small for simulation, ADDR_W at most 12");
   end

   zws_op_e           s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [NBYTES-1:0] s1_be;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [NBYTES-1:0] wr_be;
   logic [WORD_W-1:0] arr_rdata;

   zws_sram_cmd #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .sel0_n    (sel0_n),
      .sel1      (sel1),
      .sel2_n    (sel2_n),
      .wr_n      (wr_n),
      .lane_wr_n (lane_wr_n),
      .burst_adv (burst_adv),
      .burst_ilv (burst_ilv),
      .doze      (doze),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .s1_be     (s1_be)
   );

   zws_sram_wrpipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .s1_be     (s1_be),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_be     (wr_be)
   );

   zws_sram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_arr (
      .clk   (clk),
      .we    (wr_en & ~doze),
      .waddr (wr_addr),
      .wbe   (wr_be),
      .wdata (wdata),
      .raddr (s1_addr),
      .rdata (arr_rdata)
   );

   zws_sram_rdpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .drv_en_n  (drv_en_n),
      .doze      (doze),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .arr_rdata (arr_rdata),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_be     (wr_be),
      .wdata     (wdata),
      .rdata     (rdata),
      .rdata_drv (rdata_drv)
   );

endmodule

// File: tb/tb_zws_sram.sv
module tb_zws_sram;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        pm;
      logic        ilv;
      logic        adv;
      logic        wrn;
      logic        sel;
      logic [3:0]  bwn;
      logic [5:0]  a;
      logic [35:0] din;
      logic        xoe;
      logic [35:0] xdq;
   } vec_t;

   localparam logic [35:0] Z  = 36'h0;
   localparam logic [35:0] VA = 36'h1_2345_6789;
   localparam logic [35:0] VB = 36'h2_3456_789A;
   localparam logic [35:0] VC = 36'hF_FFFF_FFFF;
   localparam logic [35:0] VM = 36'h2_3456_79FF;
   localparam logic [35:0] E0 = 36'h3_0000_000C;
   localparam logic [35:0] E1 = 36'h3_0000_000D;
   localparam logic [35:0] E2 = 36'h3_0000_000E;
   localparam logic [35:0] E3 = 36'h3_0000_000F;
   localparam logic [35:0] VF = 36'h5_5555_5555;
   localparam logic [35:0] VG = 36'h6_789A_BCDE;
   localparam logic [35:0] BAD = 36'hD_EADB_EEF0;

   localparam int NV = 27;
   localparam vec_t VEC [NV] = '{
      // pipelined: alternating writes and reads, R4 data two vectors late
      '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h0,6'd8, Z, 1'b0,Z},
      '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h0,6'd9, Z, 1'b0,Z},
      '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h0,6'd8, VA,1'b0,Z},
      '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h0,6'd9, VB,1'b1,VA},
      '{1'b1,1'b0,1'b0,1'b0,1'b1,4'hE,6'd9, Z, 1'b1,VB},   // R7 lane 0 only
      '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h0,6'd9, Z, 1'b0,Z},
      '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h0,6'd9, VC,1'b1,VM},   // R6 merge on commit edge
      '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,6'd0, Z, 1'b1,VM},
      // pipelined linear write burst 12..15 (R8)
      '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h0,6'd12,Z, 1'b0,Z},
      '{1'b1,1'b0,1'b1,1'b0,1'b1,4'h0,6'd0, Z, 1'b0,Z},
      '{1'b1,1'b0,1'b1,1'b0,1'b1,4'h0,6'd0, E0,1'b0,Z},
      '{1'b1,1'b0,1'b1,1'b0,1'b1,4'h0,6'd0, E1,1'b0,Z},
      // pipelined interleaved read burst from 13: 13,12,15,14
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'h0,6'd13,E2,1'b0,Z},
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'h0,6'd0, E3,1'b1,E1},
      '{1'b1,1'b1,1'b1,1'b0,1'b1,4'h0,6'd0, Z, 1'b1,E0},   // wr_n ignored on advance
      '{1'b1,1'b1,1'b1,1'b1,1'b0,4'h0,6'd0, Z, 1'b1,E3},   // selects ignored on advance
      '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,6'd0, Z, 1'b1,E2},
      '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,6'd0, Z, 1'b0,Z},
      // flow-through: R5 data one vector late, R3 data in the same vector
      '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h0,6'd20,Z, 1'b0,Z},
      '{1'b0,1'b0,1'b0,1'b1,1'b1,4'h0,6'd20,VF,1'b1,VF},
      '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h0,6'd21,Z, 1'b0,Z},
      '{1'b0,1'b0,1'b0,1'b1,1'b1,4'h0,6'd21,VG,1'b1,VG},
      // flow-through linear read burst from 13: 13,14,15,12
      '{1'b0,1'b0,1'b0,1'b1,1'b1,4'h0,6'd13,Z, 1'b1,E1},
      '{1'b0,1'b0,1'b1,1'b1,1'b1,4'h0,6'd0, Z, 1'b1,E2},
      '{1'b0,1'b0,1'b1,1'b1,1'b1,4'h0,6'd0, Z, 1'b1,E3},
      '{1'b0,1'b0,1'b1,1'b1,1'b1,4'h0,6'd0, Z, 1'b1,E0},
      '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,6'd0, Z, 1'b0,Z}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  addr;
   logic        sel0_n, sel1, sel2_n, wr_n, burst_adv, drv_en_n, doze, pipe_mode, burst_ilv;
   logic [3:0]  lane_wr_n;
   logic [35:0] wdata;
   logic [35:0] rdata;
   logic        rdata_drv;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zws_sram dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .wr_n(wr_n), .lane_wr_n(lane_wr_n), .burst_adv(burst_adv), .drv_en_n(drv_en_n),
      .doze(doze), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv), .wdata(wdata),
      .rdata(rdata), .rdata_drv(rdata_drv)
   );

   task automatic drive(input logic pm, input logic ilv, input logic adv, input logic wrn,
                        input logic s0n, input logic s1, input logic s2n,
                        input logic [3:0] bwn, input logic [5:0] a, input logic [35:0] d);
      pipe_mode = pm; burst_ilv = ilv; burst_adv = adv; wr_n = wrn;
      sel0_n = s0n; sel1 = s1; sel2_n = s2n; lane_wr_n = bwn; addr = a; wdata = d;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic xoe, input logic [35:0] xdq);
      n_chk++;
      if (rdata_drv !== xoe || rdata !== xdq) begin
         n_fail++;
         $display("FAIL %s: drv=%0b rdata=%h, expected drv=%0b rdata=%h",
                  tag, rdata_drv, rdata, xoe, xdq);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; drv_en_n = 1'b0; doze = 1'b0;
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd0, Z);
      repeat (3) @(negedge clk);
      check("R11 outputs in reset", 1'b0, Z);
      rst_n = 1'b1;
      tick();
      check("R11 outputs after reset", 1'b0, Z);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].pm, VEC[i].ilv, VEC[i].adv, VEC[i].wrn, ~VEC[i].sel, VEC[i].sel, ~VEC[i].sel,
               VEC[i].bwn, VEC[i].a, VEC[i].din);
         tick();
         check(VEC[i].pm ? $sformatf("R2 R4 R6 R7 R8 pipelined vector %0d", i)
                         : $sformatf("R3 R5 R8 flow vector %0d", i), VEC[i].xoe, VEC[i].xdq);
      end

      // R1: each select inactive in turn blocks a write to address 8
      for (int k = 0; k < 3; k++) begin
         drive(1'b0, 1'b0, 1'b0, 1'b0, (k == 0), (k != 1), (k == 2), 4'h0, 6'd8, Z);
         tick();
         check("R1 deselected write drives nothing", 1'b0, Z);
         drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 6'd0, BAD);
         tick();
         drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd8, Z);
         tick();
         check("R1 word unchanged after deselect", 1'b1, VA);
      end

      // R8: an advance after a deselected load stays deselected
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 6'd8, Z);
      tick();
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd0, Z);
      tick();
      check("R8 advance after deselect", 1'b0, Z);

      // R9: drive enable acts between clock edges
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd8, Z);
      tick();
      drv_en_n = 1'b1; #1;
      check("R9 drivers off with drive enable high", 1'b0, Z);
      drv_en_n = 1'b0; #1;
      check("R9 drivers back on without an edge", 1'b1, VA);

      // R10: doze blocks a write and its data, and turns drivers off at once
      doze = 1'b1; #1;
      check("R10 drivers off during doze", 1'b0, Z);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'd8, Z);
      tick();
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 6'd0, BAD);
      tick();
      doze = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd8, Z);
      tick();
      check("R10 word unchanged after doze", 1'b1, VA);

      // R11: reset mid-run drops the pending read at once
      rst_n = 1'b0; #1;
      check("R11 reset clears output", 1'b0, Z);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 6'd0, Z);
      tick();
      rst_n = 1'b1;
      tick();
      check("R11 nothing pending after reset", 1'b0, Z);

      report();
      $finish;
   end

endmodule